// File: doc/BRIEF.md
# Real-Time Seconds Counter with Top-Match Interrupt

This block is a memory-mapped seconds counter that sits on a 32-bit register bus. A reference strobe, one pulse per cycle of a slow reference clock already brought into the bus clock domain, drives a free-running prescaler. The prescaler divides the strobe by a selectable power of two and produces a tick. Each tick advances a 32-bit counter that software can read and overwrite at any time.

A programmable top register can be compared against the counter. When matching is on, the tick that brings the counter to the top value sets a sticky status flag, and the following tick returns the counter to zero. When matching is off, the counter simply rolls over after all-ones. The interrupt mask is changed through separate set and clear registers and read back through a third. The status flag is cleared by writing a one. The interrupt output is a level that is high while the flag and the mask are both set.

Software usually writes the current time into the counter, loads a compare value into top, turns on matching, clears the status flag and then unmasks the interrupt.

Top module: `rt_counter`

## Requirements
- R1: After reset, every readable register returns 0 and `irq_o` is low.
- R2: The control register at byte offset 0x00 holds the run enable in bit 0, a prescaler clear in bit 1 and the match enable in bit 2. A 4-bit prescaler select sits in bits 11:8. Bit 1 acts only on the cycle it is written and always reads back as 0. The top register at 0x08 reads back what was written to it.
- R3: While running, the counter advances once every 2^(select+1) reference strobes. Select 14 gives exactly one advance per 32768 strobes.
- R4: While the run bit is 0, the counter holds its value whatever the reference strobe does.
- R5: Writing the control register, including a write that sets the prescaler clear bit or turns the run bit on, leaves the counter value unchanged. A prescaler clear restarts the division count from zero.
- R6: The counter value at 0x04 is writable. A write there wins over an increment that falls in the same cycle.
- R7: With matching on, the counter goes to zero on the tick after it equals top. With matching off, it passes the top value and rolls over from all-ones to zero.
- R8: Status bit 0 at 0x1C is set by the tick that brings the counter to top while matching is on. It stays set, even with the mask off, until a 1 is written to bit 0 at 0x20.
- R9: Writing 1 to bit 0 at 0x10 sets the mask, and writing 1 to bit 0 at 0x14 clears it. Writing 0 to either register does nothing. Bit 0 at 0x18 reads back the mask.
- R10: `irq_o` is high exactly while both the status flag and the mask are set.
- R11: Unmapped offsets read 0 and ignore writes. The mask readback and status registers ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle strobe per reference clock period |
| bus_sel_i | input | 1 | Register access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Level interrupt, status AND mask |

## Verification
The prescaler is swept over selects 0 to 5 with a strobe count just short of a whole number of periods and then one strobe more, which tells an off-by-one period apart from a correct one. Select 14 is run for its full 32768 strobes. The top-match case walks the counter tick by tick through two full cycles of a top value of 5. This separates wrapping on the tick after the match from wrapping on the match itself, and shows the status flag rising at the right tick while the interrupt stays masked. Further cases cover a counter write that coincides with a tick, a count past top with matching off, and a rollover from all-ones. Together they tell apart load priority, disabled matching and natural wrap.

// File: rtl/rt_counter_pkg.sv
package rt_counter_pkg;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned SEL_W  = 4;

  // word index = byte address >> 2
  typedef enum logic [3:0] {
    IDX_CTRL  = 4'd0,
    IDX_VALUE = 4'd1,
    IDX_TOP   = 4'd2,
    IDX_IEN   = 4'd4,
    IDX_IDIS  = 4'd5,
    IDX_IMASK = 4'd6,
    IDX_ISTAT = 4'd7,
    IDX_ICLR  = 4'd8
  } reg_idx_e;

  localparam int unsigned CTL_RUN     = 0;
  localparam int unsigned CTL_PCLR    = 1;
  localparam int unsigned CTL_MATCH   = 2;
  localparam int unsigned CTL_SEL_LSB = 8;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             match_en;
    logic             run;
  } ctrl_t;

endpackage

// File: rtl/rt_counter_prescaler.sv
module rt_counter_prescaler #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             ref_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;

  // mask keeps the low sel+1 bits
  for (genvar i = 0; i < PSC_W; i++) begin : g_mask
    assign mask[i] = (sel_i >= SEL_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             psc_q <= '0;
    else if (clr_i)          psc_q <= '0;
    else if (run_i && ref_i) psc_q <= psc_q + 1'b1;
  end

  assign tick_o = run_i && ref_i && !clr_i && ((psc_q & mask) == mask);

endmodule

// File: rtl/rt_counter_core.sv
module rt_counter_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             match_en_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = (match_en_i && (cnt_q == top_i)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_nxt;
  end

  assign hit_o = tick_i && !load_i && match_en_i && (cnt_nxt == top_i);
  assign cnt_o = cnt_q;

endmodule

// File: rtl/rt_counter_irq.sv
module rt_counter_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic mask_set_i,
  input  logic mask_clr_i,
  input  logic stat_clr_i,
  output logic mask_o,
  output logic stat_o,
  output logic irq_o
);

  logic mask_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mask_q <= 1'b0;
    else if (mask_set_i) mask_q <= 1'b1;
    else if (mask_clr_i) mask_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stat_q <= 1'b0;
    else if (hit_i)      stat_q <= 1'b1;
    else if (stat_clr_i) stat_q <= 1'b0;
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = stat_q & mask_q;

endmodule

// File: rtl/rt_counter.sv
module rt_counter
  import rt_counter_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  localparam int unsigned CNT_W = DATA_W;
  localparam int unsigned PSC_W = 1 << SEL_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] top_q;
  logic [CNT_W-1:0] cnt_w;
  logic             tick_w, hit_w, imask_w, istat_w;
  logic [3:0]       idx;
  logic             wr_en;
  logic             wr_ctrl, wr_val, wr_top, wr_ien, wr_idis, wr_iclr, pclr;
  logic             unused_addr;

  assign idx         = bus_addr_i[ADDR_W-1:2];
  assign unused_addr = ^bus_addr_i[1:0];
  assign wr_en       = bus_sel_i && bus_wr_i;
  assign wr_ctrl     = wr_en && (idx == IDX_CTRL);
  assign wr_val      = wr_en && (idx == IDX_VALUE);
  assign wr_top      = wr_en && (idx == IDX_TOP);
  assign wr_ien      = wr_en && (idx == IDX_IEN)  && bus_wdata_i[0];
  assign wr_idis     = wr_en && (idx == IDX_IDIS) && bus_wdata_i[0];
  assign wr_iclr     = wr_en && (idx == IDX_ICLR) && bus_wdata_i[0];
  assign pclr        = wr_ctrl && bus_wdata_i[CTL_PCLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.run      <= bus_wdata_i[CTL_RUN];
      ctrl_q.match_en <= bus_wdata_i[CTL_MATCH];
      ctrl_q.sel      <= bus_wdata_i[CTL_SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_q <= '0;
    else if (wr_top) top_q <= bus_wdata_i;
  end

  rt_counter_prescaler #(.SEL_W(SEL_W), .PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .clr_i  (pclr),
    .ref_i  (ref_tick_i),
    .sel_i  (ctrl_q.sel),
    .tick_o (tick_w)
  );

  rt_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .match_en_i (ctrl_q.match_en),
    .top_i      (top_q),
    .load_i     (wr_val),
    .load_val_i (bus_wdata_i),
    .cnt_o      (cnt_w),
    .hit_o      (hit_w)
  );

  rt_counter_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit_w),
    .mask_set_i (wr_ien),
    .mask_clr_i (wr_idis),
    .stat_clr_i (wr_iclr),
    .mask_o     (imask_w),
    .stat_o     (istat_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (idx)
      IDX_CTRL: begin
        bus_rdata_o[CTL_RUN]                  = ctrl_q.run;
        bus_rdata_o[CTL_MATCH]                = ctrl_q.match_en;
        bus_rdata_o[CTL_SEL_LSB +: SEL_W]     = ctrl_q.sel;
      end
      IDX_VALUE: bus_rdata_o    = cnt_w;
      IDX_TOP:   bus_rdata_o    = top_q;
      IDX_IMASK: bus_rdata_o[0] = imask_w;
      IDX_ISTAT: bus_rdata_o[0] = istat_w;
      default:   bus_rdata_o    = '0;
    endcase
  end

endmodule

// File: rtl/rt_counter_chk.sv
module rt_counter_chk
  import rt_counter_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_o,
  input logic              run_i,
  input logic [DATA_W-1:0] cnt_i,
  input logic              mask_i,
  input logic              stat_i
);

  logic wr_val, wr_ien, wr_iclr, rd_ctrl;
  assign wr_val  = bus_sel_i && bus_wr_i && (bus_addr_i[ADDR_W-1:2] == IDX_VALUE);
  assign wr_ien  = bus_sel_i && bus_wr_i && (bus_addr_i[ADDR_W-1:2] == IDX_IEN) && bus_wdata_i[0];
  assign wr_iclr = bus_sel_i && bus_wr_i && (bus_addr_i[ADDR_W-1:2] == IDX_ICLR) && bus_wdata_i[0];
  assign rd_ctrl = bus_sel_i && !bus_wr_i && (bus_addr_i[ADDR_W-1:2] == IDX_CTRL);

  AST_PCLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctrl |-> !bus_rdata_o[CTL_PCLR]); // R2

  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_val) |=> (cnt_i == $past(cnt_i))); // R4

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_val |=> (cnt_i == $past(bus_wdata_i))); // R6

  AST_STEP_OR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_val |=> (cnt_i == $past(cnt_i) || cnt_i == DATA_W'($past(cnt_i) + 1'b1) || cnt_i == '0)); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i && !wr_iclr) |=> stat_i); // R8

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ien |=> mask_i); // R9

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_i && mask_i)); // R10

endmodule

bind rt_counter rt_counter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .run_i       (ctrl_q.run),
  .cnt_i       (cnt_w),
  .mask_i      (imask_w),
  .stat_i      (istat_w)
);

// File: tb/rt_counter_test.sv
`timescale 1ns/1ps
module rt_counter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bsel = 1'b0;
  logic        bwr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [5:0] A_CTRL = 6'h00, A_VAL = 6'h04, A_TOP = 6'h08, A_IEN = 6'h10,
                         A_IDIS = 6'h14, A_IMASK = 6'h18, A_ISTAT = 6'h1C, A_ICLR = 6'h20,
                         A_HOLE = 6'h0C;
  localparam logic [31:0] C_RUN = 32'h1, C_PCLR = 32'h2, C_MATCH = 32'h4;

  always #4 clk = ~clk;

  rt_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick),
    .bus_sel_i(bsel), .bus_wr_i(bwr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bsel = 1'b1; bwr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    bsel = 1'b0; bwr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bsel = 1'b1; bwr = 1'b0; addr = a;
    #1 d = rdata;
    bsel = 1'b0;
  endtask

  task automatic pulse(input int n);
    if (n > 0) begin
      @(negedge clk);
      ref_tick = 1'b1;
      repeat (n) @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_VAL, v);   chk("R1 value", v, 0);
    rd(A_TOP, v);   chk("R1 top", v, 0);
    rd(A_IMASK, v); chk("R1 mask", v, 0);
    rd(A_ISTAT, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 control readback, clear bit not stored
    wr(A_CTRL, C_RUN | C_PCLR | C_MATCH | (32'd3 << 8));
    rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h305);
    wr(A_TOP, 32'hDEADBEEF);
    rd(A_TOP, v); chk("R2 top readback", v, 32'hDEADBEEF);

    // R3 prescaler sweep
    for (int s = 0; s <= 5; s++) begin
      int per;
      per = 1 << (s + 1);
      wr(A_CTRL, C_RUN | C_PCLR | (32'(s) << 8));
      wr(A_VAL, 0);
      pulse(3 * per - 1);
      rd(A_VAL, v); chk($sformatf("R3 sel%0d short", s), v, 2);
      pulse(1);
      rd(A_VAL, v); chk($sformatf("R3 sel%0d full", s), v, 3);
    end
    wr(A_CTRL, C_RUN | C_PCLR | (32'd14 << 8));
    wr(A_VAL, 0);
    pulse(32767);
    rd(A_VAL, v); chk("R3 sel14 short", v, 0);
    pulse(1);
    rd(A_VAL, v); chk("R3 sel14 one second", v, 1);

    // R4 hold while stopped
    wr(A_CTRL, 32'h0);
    wr(A_VAL, 7);
    pulse(20);
    rd(A_VAL, v); chk("R4 hold stopped", v, 7);

    // R5 control writes keep the value; clear restarts division
    wr(A_CTRL, C_RUN | C_PCLR | (32'd1 << 8));
    rd(A_VAL, v); chk("R5 value kept", v, 7);
    pulse(3);
    wr(A_CTRL, C_RUN | C_PCLR | (32'd1 << 8));
    pulse(3);
    rd(A_VAL, v); chk("R5 clear restarts", v, 7);
    pulse(1);
    rd(A_VAL, v); chk("R5 after restart", v, 8);

    // R6 write wins over same-cycle tick (sel 0: tick on 2nd strobe)
    wr(A_CTRL, C_RUN | C_PCLR);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); bsel = 1'b1; bwr = 1'b1; addr = A_VAL; wdata = 100;
    @(negedge clk); bsel = 1'b0; bwr = 1'b0; ref_tick = 1'b0;
    rd(A_VAL, v); chk("R6 load beats tick", v, 100);

    // R7/R8/R10 top match walk, top = 5, mask off
    wr(A_TOP, 5);
    wr(A_CTRL, C_RUN | C_PCLR | C_MATCH);
    wr(A_VAL, 0);
    for (int t = 1; t <= 14; t++) begin
      pulse(2);
      rd(A_VAL, v); chk($sformatf("R7 wrap t=%0d", t), v, 32'(t % 6));
      rd(A_ISTAT, v); chk($sformatf("R8 status t=%0d", t), v, (t >= 5) ? 1 : 0);
      chk($sformatf("R10 masked irq t=%0d", t), {31'b0, irq}, 0);
    end

    // R9/R10 mask control
    wr(A_IEN, 0);
    rd(A_IMASK, v); chk("R9 zero to set ignored", v, 0);
    wr(A_IEN, 1);
    rd(A_IMASK, v); chk("R9 set mask", v, 1);
    chk("R10 irq high", {31'b0, irq}, 1);
    wr(A_IDIS, 0);
    rd(A_IMASK, v); chk("R9 zero to clear ignored", v, 1);
    wr(A_ICLR, 0);
    rd(A_ISTAT, v); chk("R8 zero to clear ignored", v, 1);
    wr(A_ICLR, 1);
    rd(A_ISTAT, v); chk("R8 status cleared", v, 0);
    chk("R10 irq low after clear", {31'b0, irq}, 0);
    wr(A_IDIS, 1);
    rd(A_IMASK, v); chk("R9 clear mask", v, 0);

    // R7 matching off: passes top, then natural rollover
    wr(A_CTRL, C_RUN | C_PCLR);
    wr(A_VAL, 4);
    pulse(6);
    rd(A_VAL, v); chk("R7 passes top", v, 7);
    rd(A_ISTAT, v); chk("R8 no status when off", v, 0);
    wr(A_VAL, 32'hFFFF_FFFF);
    pulse(2);
    rd(A_VAL, v); chk("R7 rollover", v, 0);

    // R11 unmapped and read-only registers
    wr(A_HOLE, 32'hAB);
    rd(A_HOLE, v); chk("R11 hole reads zero", v, 0);
    wr(A_ISTAT, 1);
    rd(A_ISTAT, v); chk("R11 status read-only", v, 0);
    wr(A_IMASK, 1);
    rd(A_IMASK, v); chk("R11 mask readback read-only", v, 0);
    rd(A_VAL, v); chk("R11 value untouched", v, 0);

    summary();
  end

endmodule